// File: doc/BRIEF.md
# DDR SDRAM Burst Mode Register and Column Sequencer

This block keeps the two mode registers of a double-data-rate SDRAM, the regular one and the extended one, and produces the column address of every data beat in a burst. A register-set strobe loads a 13-bit operand. A 2-bit selector picks which register receives it. The block decodes the operand into these settings: burst length, wrap order, read latency in half clocks, the DLL reset request, a test-mode bit, DLL disable and reduced drive strength.

When a burst start pulse arrives with a start column, the sequencer latches the column and the current burst settings. It then presents two column addresses per clock, one for each data beat, for BL/2 clocks. The low burst-field bits wrap inside the block aligned to the burst length. Sequential order adds the beat index without carrying out of the field. Interleaved order XORs the beat index into the field.

Top module: `burst_mode_unit`

## Requirements
- R1: A strobe with selector 00 writes the regular register. Operand bit 3 sets the wrap order (0 sequential, 1 interleaved). Bit 8 drives the DLL reset request. Bit 7 drives the test-mode flag. All outputs update on the clock after the strobe.
- R2: A strobe with selector 01 writes the extended register. Operand bit 0 sets DLL disable and bit 1 sets half drive strength. The regular settings do not change.
- R3: A strobe with selector bit 1 set (10 or 11) changes no output.
- R4: Operand bits 2..0 select the burst length: 001 gives 2 beats, 010 gives 4 and 011 gives 8. Any other code leaves the previous length in place and raises the error flag.
- R5: Operand bits 6..4 select the latency, reported in half clocks: 010 gives 4 and 110 gives 5. Any other code leaves the previous latency in place and raises the error flag. The other fields of that write still take effect.
- R6: The error flag is set by a regular write that carries a reserved length or latency code. It is cleared by a regular write in which both codes are valid.
- R7: After reset the not-programmed flag is 1, the length is 2, the order is sequential, the latency is 4 half clocks, every other setting is 0, the error flag is 0 and no burst is active. The not-programmed flag falls after the first regular write and stays low until the next reset.
- R8: In sequential order, beat k of a burst uses the start column with its low log2(BL) bits replaced by (those bits + k) mod BL. The higher bits are left unchanged.
- R9: In interleaved order, beat k uses the start column with its low log2(BL) bits XORed with k.
- R10: Beats 2i and 2i+1 appear on the two column outputs in the i-th clock after the start pulse is captured, with the valid output high, for exactly BL/2 clocks. The last-pair output marks the final clock.
- R11: A burst keeps the length and order that were in force when it started. A register write during the burst does not affect it, and a start pulse before its last clock is ignored.
- R12: A start pulse in the last clock of a burst is accepted. The next burst follows with no idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_wr | input | 1 | Register-set strobe |
| mr_sel | input | 2 | Register selector (00 regular, 01 extended, 1x ignored) |
| mr_op | input | 13 | Register operand |
| burst_go | input | 1 | Burst start pulse |
| start_col | input | 9 | Start column of the burst |
| cfg_bl | output | 4 | Burst length in beats |
| cfg_ilv | output | 1 | Interleaved wrap order |
| cfg_cl_half | output | 3 | Read latency in half clocks |
| cfg_dll_rst | output | 1 | DLL reset request |
| cfg_test | output | 1 | Test-mode bit |
| cfg_dll_off | output | 1 | DLL disabled |
| cfg_half_drv | output | 1 | Half drive strength |
| cfg_err | output | 1 | Last regular write held a reserved code |
| cfg_unprog | output | 1 | Regular register not yet written |
| seq_vld | output | 1 | Column pair valid |
| seq_last | output | 1 | Final pair of the burst |
| seq_col0 | output | 9 | Column of the even beat |
| seq_col1 | output | 9 | Column of the odd beat |

## Verification
The bench starts bursts from columns whose low field is not zero, so that the wrap is exercised. A design that carried out of the burst field would corrupt the higher column bits. A design that swapped the two orders would produce 5,6,7,0 where 5,4,7,6 is expected. Reserved length and latency codes are written both separately and together. This catches a design that loads the reserved value, that drops the fields written alongside it, or that never clears the error. Reserved selectors must leave every setting untouched. Bursts are also started while a register write lands mid-burst, with a start pulse arriving mid-burst and with a start pulse in the final clock. These cases expose a sequencer that reads live settings, restarts early or inserts an idle clock.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

   localparam logic [1:0] SEL_STD = 2'b00;
   localparam logic [1:0] SEL_EXT = 2'b01;

   typedef struct packed {
      logic       ok;
      logic [3:0] beats;
   } bl_dec_t;

   typedef struct packed {
      logic       ok;
      logic [2:0] half;
   } cl_dec_t;

   function automatic bl_dec_t dec_len(input logic [2:0] code);
      bl_dec_t r;
      r.ok = 1'b1;
      case (code)
         3'b001:  r.beats = 4'd2;
         3'b010:  r.beats = 4'd4;
         3'b011:  r.beats = 4'd8;
         default: begin r.beats = 4'd2; r.ok = 1'b0; end
      endcase
      return r;
   endfunction

   function automatic cl_dec_t dec_lat(input logic [2:0] code);
      cl_dec_t r;
      r.ok = 1'b1;
      case (code)
         3'b010:  r.half = 3'd4;
         3'b110:  r.half = 3'd5;
         default: begin r.half = 3'd4; r.ok = 1'b0; end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bmu_mode_regs.sv
module bmu_mode_regs
   import bmu_pkg::*;
#(
   parameter int OP_W  = 13,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] sel,
   input  logic [OP_W-1:0]  op,
   output logic [3:0]       bl,
   output logic             ilv,
   output logic [2:0]       cl_half,
   output logic             dll_rst,
   output logic             test_md,
   output logic             dll_off,
   output logic             half_drv,
   output logic             err,
   output logic             unprog
);

   initial begin
      if (OP_W < 9)  $error("bmu_mode_regs: operand too narrow");
      if (SEL_W != 2) $error("bmu_mode_regs: selector must be 2 bits");
   end

   logic    std_wr, ext_wr;
   bl_dec_t len_d;
   cl_dec_t lat_d;

   assign std_wr = wr && (sel == SEL_STD);
   assign ext_wr = wr && (sel == SEL_EXT);
   assign len_d  = dec_len(op[2:0]);
   assign lat_d  = dec_lat(op[6:4]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bl       <= 4'd2;
         ilv      <= 1'b0;
         cl_half  <= 3'd4;
         dll_rst  <= 1'b0;
         test_md  <= 1'b0;
         dll_off  <= 1'b0;
         half_drv <= 1'b0;
         err      <= 1'b0;
         unprog   <= 1'b1;
      end else begin
         if (std_wr) begin
            if (len_d.ok) bl      <= len_d.beats;
            if (lat_d.ok) cl_half <= lat_d.half;
            ilv     <= op[3];
            test_md <= op[7];
            dll_rst <= op[8];
            err     <= !(len_d.ok && lat_d.ok);
            unprog  <= 1'b0;
         end
         if (ext_wr) begin
            dll_off  <= op[0];
            half_drv <= op[1];
         end
      end
   end

endmodule

// File: rtl/bmu_col_gen.sv
module bmu_col_gen #(
   parameter int COL_W  = 9,
   parameter int MAX_BL = 8,
   parameter int LANES  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic [COL_W-1:0]       start,
   input  logic [3:0]             bl,
   input  logic                   ilv,
   output logic                   vld,
   output logic                   last,
   output logic [LANES*COL_W-1:0] cols
);

   localparam int BF_W   = $clog2(MAX_BL);
   localparam int PAIR_W = BF_W - $clog2(LANES);

   initial begin
      if (MAX_BL != 8)     $error("bmu_col_gen: burst field sized for 8 beats");
      if (LANES != 2)      $error("bmu_col_gen: two beats per clock expected");
      if (COL_W <= BF_W)   $error("bmu_col_gen: column narrower than burst field");
   end

   logic [COL_W-1:0]  start_q;
   logic [3:0]        bl_q;
   logic              ilv_q;
   logic [PAIR_W-1:0] pair_q;
   logic [BF_W-1:0]   mask;
   logic              take;

   assign mask = BF_W'(bl_q - 4'd1);
   assign last = vld && (pair_q == PAIR_W'((bl_q >> 1) - 4'd1));
   assign take = go && (!vld || last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld     <= 1'b0;
         start_q <= '0;
         bl_q    <= 4'd2;
         ilv_q   <= 1'b0;
         pair_q  <= '0;
      end else if (take) begin
         vld     <= 1'b1;
         start_q <= start;
         bl_q    <= bl;
         ilv_q   <= ilv;
         pair_q  <= '0;
      end else if (vld) begin
         if (last) vld <= 1'b0;
         else      pair_q <= pair_q + 1'b1;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BF_W-1:0] k, base, nxt;
      assign k    = {pair_q, ($clog2(LANES))'(g)};
      assign base = start_q[BF_W-1:0];
      assign nxt  = ilv_q ? (base ^ k) : (base + k);
      assign cols[g*COL_W +: COL_W] =
         {start_q[COL_W-1:BF_W], (base & ~mask) | (nxt & mask)};
   end

endmodule

// File: rtl/burst_mode_unit.sv
module burst_mode_unit
   import bmu_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter int OP_W   = 13,
   parameter int SEL_W  = 2,
   parameter int MAX_BL = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mr_wr,
   input  logic [SEL_W-1:0] mr_sel,
   input  logic [OP_W-1:0]  mr_op,
   input  logic             burst_go,
   input  logic [COL_W-1:0] start_col,
   output logic [3:0]       cfg_bl,
   output logic             cfg_ilv,
   output logic [2:0]       cfg_cl_half,
   output logic             cfg_dll_rst,
   output logic             cfg_test,
   output logic             cfg_dll_off,
   output logic             cfg_half_drv,
   output logic             cfg_err,
   output logic             cfg_unprog,
   output logic             seq_vld,
   output logic             seq_last,
   output logic [COL_W-1:0] seq_col0,
   output logic [COL_W-1:0] seq_col1
);

   localparam int LANES = 2;

   logic [LANES*COL_W-1:0] cols;

   bmu_mode_regs #(.OP_W(OP_W), .SEL_W(SEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (mr_wr),
      .sel      (mr_sel),
      .op       (mr_op),
      .bl       (cfg_bl),
      .ilv      (cfg_ilv),
      .cl_half  (cfg_cl_half),
      .dll_rst  (cfg_dll_rst),
      .test_md  (cfg_test),
      .dll_off  (cfg_dll_off),
      .half_drv (cfg_half_drv),
      .err      (cfg_err),
      .unprog   (cfg_unprog)
   );

   bmu_col_gen #(.COL_W(COL_W), .MAX_BL(MAX_BL), .LANES(LANES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (burst_go),
      .start (start_col),
      .bl    (cfg_bl),
      .ilv   (cfg_ilv),
      .vld   (seq_vld),
      .last  (seq_last),
      .cols  (cols)
   );

   assign seq_col0 = cols[0 +: COL_W];
   assign seq_col1 = cols[COL_W +: COL_W];

endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
   parameter int COL_W = 9,
   parameter int OP_W  = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mr_wr,
   input logic [1:0]       mr_sel,
   input logic [OP_W-1:0]  mr_op,
   input logic [3:0]       cfg_bl,
   input logic             cfg_ilv,
   input logic [2:0]       cfg_cl_half,
   input logic             cfg_dll_off,
   input logic             cfg_half_drv,
   input logic             cfg_unprog,
   input logic             seq_vld,
   input logic             seq_last,
   input logic [COL_W-1:0] seq_col0,
   input logic [COL_W-1:0] seq_col1
);

   p_ext_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_wr && mr_sel == 2'b01) |=> (cfg_dll_off == $past(mr_op[0]) &&
                                      cfg_half_drv == $past(mr_op[1])));

   p_reserved_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_wr && mr_sel[1]) |=> ($stable(cfg_bl) && $stable(cfg_ilv) &&
                                $stable(cfg_cl_half) && $stable(cfg_dll_off) &&
                                $stable(cfg_half_drv)));

   p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(cfg_bl) == 1) && !cfg_bl[0]);

   p_lat_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cl_half == 3'd4) || (cfg_cl_half == 3'd5));

   p_unprog_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_unprog) |-> $past(mr_wr && mr_sel == 2'b00));

   p_unprog_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_unprog |=> !cfg_unprog);

   p_same_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_vld |-> (seq_col0[COL_W-1:3] == seq_col1[COL_W-1:3]));

   p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_last |-> seq_vld);

endmodule

bind burst_mode_unit bmu_checker #(.COL_W(COL_W), .OP_W(OP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mr_wr        (mr_wr),
   .mr_sel       (mr_sel),
   .mr_op        (mr_op),
   .cfg_bl       (cfg_bl),
   .cfg_ilv      (cfg_ilv),
   .cfg_cl_half  (cfg_cl_half),
   .cfg_dll_off  (cfg_dll_off),
   .cfg_half_drv (cfg_half_drv),
   .cfg_unprog   (cfg_unprog),
   .seq_vld      (seq_vld),
   .seq_last     (seq_last),
   .seq_col0     (seq_col0),
   .seq_col1     (seq_col1)
);

// File: tb/sim_burst_mode_unit.sv
`timescale 1ns/1ps
module sim_burst_mode_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mr_wr = 1'b0;
   logic [1:0]  mr_sel = 2'b00;
   logic [12:0] mr_op = '0;
   logic        burst_go = 1'b0;
   logic [8:0]  start_col = '0;
   logic [3:0]  cfg_bl;
   logic        cfg_ilv, cfg_dll_rst, cfg_test, cfg_dll_off, cfg_half_drv;
   logic        cfg_err, cfg_unprog, seq_vld, seq_last;
   logic [2:0]  cfg_cl_half;
   logic [8:0]  seq_col0, seq_col1;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   burst_mode_unit u0 (
      .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .mr_sel(mr_sel), .mr_op(mr_op),
      .burst_go(burst_go), .start_col(start_col), .cfg_bl(cfg_bl),
      .cfg_ilv(cfg_ilv), .cfg_cl_half(cfg_cl_half), .cfg_dll_rst(cfg_dll_rst),
      .cfg_test(cfg_test), .cfg_dll_off(cfg_dll_off), .cfg_half_drv(cfg_half_drv),
      .cfg_err(cfg_err), .cfg_unprog(cfg_unprog), .seq_vld(seq_vld),
      .seq_last(seq_last), .seq_col0(seq_col0), .seq_col1(seq_col1)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] want_col(input logic [8:0] s, input int bl,
                                           input bit ilv, input int k);
      logic [2:0] m, lo, v;
      m  = 3'(bl - 1);
      lo = s[2:0];
      v  = ilv ? (lo ^ 3'(k)) : 3'(lo + 3'(k));
      return {s[8:3], (lo & ~m) | (v & m)};
   endfunction

   task automatic wr_reg(input logic [1:0] sel, input logic [12:0] op);
      @(negedge clk);
      mr_wr = 1'b1; mr_sel = sel; mr_op = op;
      @(negedge clk);
      mr_wr = 1'b0;
   endtask

   // Runs a burst and checks every pair; optional mid-burst register write
   // (during pair 1) and mid-burst start pulse (during pair 0).
   task automatic run_burst(input string req, input logic [8:0] s, input int bl,
                            input bit ilv, input bit poke_reg, input bit poke_go);
      @(negedge clk);
      burst_go = 1'b1; start_col = s;
      for (int i = 0; i < bl / 2; i++) begin
         @(negedge clk);
         burst_go = (poke_go && i == 0) ? 1'b1 : 1'b0;
         start_col = poke_go ? 9'h000 : s;
         mr_wr = (poke_reg && i == 1); mr_sel = 2'b00; mr_op = 13'h0021;
         chk({req, " valid"}, 16'(seq_vld), 16'd1);
         chk({req, " col0"}, 16'(seq_col0), 16'(want_col(s, bl, ilv, 2 * i)));
         chk({req, " col1"}, 16'(seq_col1), 16'(want_col(s, bl, ilv, 2 * i + 1)));
         chk({req, " last"}, 16'(seq_last), 16'(i == bl / 2 - 1));
      end
      @(negedge clk);
      burst_go = 1'b0; mr_wr = 1'b0;
      chk({req, " idle after"}, 16'(seq_vld), 16'd0);
   endtask

   task automatic t_reset;
      chk("R7 unprog", 16'(cfg_unprog), 16'd1);
      chk("R7 bl", 16'(cfg_bl), 16'd2);
      chk("R7 cl", 16'(cfg_cl_half), 16'd4);
      chk("R7 err", 16'(cfg_err), 16'd0);
      chk("R7 vld", 16'(seq_vld), 16'd0);
      chk("R7 misc", 16'({cfg_ilv, cfg_dll_rst, cfg_test, cfg_dll_off, cfg_half_drv}), 16'd0);
   endtask

   task automatic t_regular;
      wr_reg(2'b00, 13'h0122);  // bl 4, seq, cl 2, dll reset
      chk("R1 bl", 16'(cfg_bl), 16'd4);
      chk("R1 cl", 16'(cfg_cl_half), 16'd4);
      chk("R1 dllrst", 16'(cfg_dll_rst), 16'd1);
      chk("R7 unprog low", 16'(cfg_unprog), 16'd0);
      wr_reg(2'b00, 13'h00EB);  // bl 8, ilv, cl 2.5, test bit
      chk("R4 bl8", 16'(cfg_bl), 16'd8);
      chk("R1 ilv", 16'(cfg_ilv), 16'd1);
      chk("R5 cl5", 16'(cfg_cl_half), 16'd5);
      chk("R1 test", 16'(cfg_test), 16'd1);
      chk("R1 dllrst off", 16'(cfg_dll_rst), 16'd0);
      chk("R6 err", 16'(cfg_err), 16'd0);
   endtask

   task automatic t_extended;
      wr_reg(2'b01, 13'h0003);
      chk("R2 dll off", 16'(cfg_dll_off), 16'd1);
      chk("R2 half", 16'(cfg_half_drv), 16'd1);
      chk("R2 bl kept", 16'(cfg_bl), 16'd8);
      chk("R2 cl kept", 16'(cfg_cl_half), 16'd5);
   endtask

   task automatic t_ignored;
      wr_reg(2'b10, 13'h0000);
      wr_reg(2'b11, 13'h0000);
      chk("R3 bl", 16'(cfg_bl), 16'd8);
      chk("R3 ilv", 16'(cfg_ilv), 16'd1);
      chk("R3 cl", 16'(cfg_cl_half), 16'd5);
      chk("R3 ext", 16'({cfg_dll_off, cfg_half_drv}), 16'd3);
      chk("R3 test", 16'(cfg_test), 16'd1);
   endtask

   task automatic t_reserved;
      wr_reg(2'b00, 13'h0025);  // bl reserved, cl 2
      chk("R4 bl kept", 16'(cfg_bl), 16'd8);
      chk("R5 cl new", 16'(cfg_cl_half), 16'd4);
      chk("R6 err set", 16'(cfg_err), 16'd1);
      chk("R5 ilv new", 16'(cfg_ilv), 16'd0);
      wr_reg(2'b00, 13'h0031);  // bl 2, cl reserved
      chk("R4 bl2", 16'(cfg_bl), 16'd2);
      chk("R5 cl kept", 16'(cfg_cl_half), 16'd4);
      chk("R6 err still", 16'(cfg_err), 16'd1);
      wr_reg(2'b00, 13'h0022);
      chk("R6 err clear", 16'(cfg_err), 16'd0);
      chk("R4 bl4", 16'(cfg_bl), 16'd4);
   endtask

   task automatic t_sequential;
      wr_reg(2'b00, 13'h0023);
      run_burst("R8 seq8", 9'h1F5, 8, 1'b0, 1'b0, 1'b0);
      wr_reg(2'b00, 13'h0022);
      run_burst("R8 seq4", 9'h00E, 4, 1'b0, 1'b0, 1'b0);
      wr_reg(2'b00, 13'h0021);
      run_burst("R8 seq2", 9'h00B, 2, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_interleave;
      wr_reg(2'b00, 13'h002B);
      run_burst("R9 ilv8", 9'h1F5, 8, 1'b1, 1'b0, 1'b0);
      wr_reg(2'b00, 13'h002A);
      run_burst("R9 ilv4", 9'h0A6, 4, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_latched;
      wr_reg(2'b00, 13'h0023);
      run_burst("R11 hold", 9'h133, 8, 1'b0, 1'b1, 1'b1);
      chk("R11 reg took", 16'(cfg_bl), 16'd2);
   endtask

   task automatic t_back_to_back;
      wr_reg(2'b00, 13'h0022);
      @(negedge clk);
      burst_go = 1'b1; start_col = 9'h045;
      @(negedge clk);
      burst_go = 1'b0;
      chk("R10 pair0", 16'(seq_col0), 16'h045);
      @(negedge clk);
      burst_go = 1'b1; start_col = 9'h0C3;
      chk("R12 last", 16'(seq_last), 16'd1);
      @(negedge clk);
      burst_go = 1'b0;
      chk("R12 no gap", 16'(seq_vld), 16'd1);
      chk("R12 new col0", 16'(seq_col0), 16'h0C3);
      chk("R12 new col1", 16'(seq_col1), 16'h0C0);
      @(negedge clk);
      chk("R12 second pair", 16'(seq_col0), 16'h0C1);
      @(negedge clk);
      chk("R12 done", 16'(seq_vld), 16'd0);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regular();
      t_extended();
      t_ignored();
      t_reserved();
      t_sequential();
      t_interleave();
      t_latched();
      t_back_to_back();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule